// File: doc/BRIEF.md
# Multi-Thread Gate Control List Engine

This block is the egress time gating core of a small switch. One linear table of gate-control entries is kept in a register-file RAM. Up to eight execution threads walk that table. Each thread owns a contiguous slice of entries, bounded by a start address and an end index. Each thread is launched once the external PTP time reaches a shared schedule start time plus a per-thread offset, measured in delta units. It then loops over its slice forever, keeping each entry in force for that entry's own number of deltas.

Each entry names the ports it governs and the traffic classes it holds closed. For every port, the block merges the closed masks of all threads whose current entry addresses that port. It then presents the complement as the set of classes that may transmit.

Software loads the table and the per-thread settings through two simple write ports. It selects the PTP time source and issues single-cycle start and stop pulses. A start is refused, and an error is flagged, when the thread settings are inconsistent.

Top module: `gcl_engine`

## Requirements
- R1: After reset `sched_started` is 0, `sched_stopped` is 1, `cfg_err` is 0, and every bit of `gate_open` is 1.
- R2: `clk_src` encodes 0 = off, 1 = free-running, 2 = reserved and 3 = PTP. A `cmd_start` pulse is acted on only when `clk_src` is 3 and the engine is stopped; otherwise it changes nothing. An accepted start sets `sched_started` and clears `sched_stopped` after that clock edge.
- R3: A start is refused, and `cfg_err` is set, in either of two cases. The first is that the end indices of threads 0 to N_THR-1 are not non-decreasing. The second is that an active thread (index not above `act_thr`) has an entry-point delta of 0. An accepted start clears `cfg_err`. Inactive threads may hold a zero delta.
- R4: Consider an active thread i while the engine runs. At the first clock edge that samples `ptp_time` >= `start_time` + delta_i × TICKS_PER_DELTA (25), the thread starts at its start address. Threads whose index exceeds `act_thr` never run.
- R5: A running thread holds its current entry for delta × TICKS_PER_DELTA clock cycles, where a delta of 0 counts as 1. It then moves to the next index. After its end index it returns to its start address.
- R6: Entry word layout: bits [N_TC-1:0] hold the closed mask (1 = class gate closed). Bit N_TC is the reserved-media enable. Bits [N_TC+1 +: N_PORTS] hold the destination port mask, and the top DELTA_W bits hold the delta count. An entry whose enable is 0 has no effect on any gate.
- R7: `gate_open[p*N_TC +: N_TC]` is the inverse of the OR of the closed masks of all running threads whose current, enabled entry includes port p. A port addressed by no such entry has all classes open.
- R8: A `cmd_stop` pulse halts all threads at the same edge. It clears `sched_started` and sets `sched_stopped`, and every gate is open from the next cycle on. Stop wins over a simultaneous start.
- R9: If `ptp_time` is already past a thread's launch time when a start is accepted, the thread begins at its start address one clock after the edge that accepted the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock, one tick per cycle |
| rst_n | input | 1 | Active-low reset |
| tbl_we | input | 1 | Entry table write strobe |
| tbl_addr | input | IDX_W | Entry table write address |
| tbl_wdata | input | ENT_W | Entry word (layout in R6) |
| thr_we | input | 1 | Thread settings write strobe |
| thr_sel | input | SEL_W | Thread being written |
| thr_start | input | IDX_W | Thread start address |
| thr_end | input | IDX_W | Thread end index |
| thr_epd | input | EPD_W | Thread entry-point delta, in deltas |
| clk_src | input | 2 | Time source select |
| act_thr | input | SEL_W | Number of active threads minus one |
| start_time | input | TIME_W | Schedule start time, in ticks |
| ptp_time | input | TIME_W | Current PTP time, in ticks |
| cmd_start | input | 1 | Single-cycle start command |
| cmd_stop | input | 1 | Single-cycle stop command |
| sched_started | output | 1 | Schedule running status |
| sched_stopped | output | 1 | Schedule stopped status |
| cfg_err | output | 1 | Last start refused for bad settings |
| gate_open | output | N_PORTS*N_TC | Per-port transmit-allowed class mask |

## Verification
The hardest situation to reach from the ports is the overlap of two threads with different periods on the same port. That requires a second thread to launch part-way through the first thread's slice, and both to wrap at different times. The stimulus runs two threads with cycles of three and four deltas, offset by two deltas, from a free-running PTP counter. Sampling points are chosen on both sides of every launch, every entry change and each thread's first wrap. The late-start case is reached by stopping, corrupting and then repairing the settings, so that the final start lands after both launch times have passed.

// File: rtl/gcl_pkg.sv
package gcl_pkg;
   // Time source select; only the PTP code allows the engine to start.
   typedef enum logic [1:0] {
      SRC_OFF  = 2'd0,
      SRC_FREE = 2'd1,
      SRC_RSVD = 2'd2,
      SRC_PTP  = 2'd3
   } tsrc_e;
endpackage

// File: rtl/gcl_cfg_check.sv
module gcl_cfg_check #(
   parameter int N_THR = 8,
   parameter int IDX_W = 4,
   parameter int EPD_W = 12,
   parameter int SEL_W = 3
) (
   input  logic [N_THR-1:0][IDX_W-1:0] end_idx,
   input  logic [N_THR-1:0][EPD_W-1:0] epd,
   input  logic [SEL_W-1:0]            act_thr,
   output logic                        cfg_ok
);
   logic [N_THR-1:0] bad_end;
   logic [N_THR-1:0] bad_epd;

   for (genvar t = 0; t < N_THR; t++) begin : g_chk
      if (t == 0) begin : g_first
         assign bad_end[t] = 1'b0;
      end else begin : g_rest
         assign bad_end[t] = end_idx[t] < end_idx[t-1];
      end
      assign bad_epd[t] = (SEL_W'(t) <= act_thr) && (epd[t] == '0);
   end

   assign cfg_ok = ~|{bad_end, bad_epd};
endmodule

// File: rtl/gcl_thread.sv
module gcl_thread #(
   parameter int IDX_W   = 4,
   parameter int DELTA_W = 8,
   parameter int EPD_W   = 12,
   parameter int TIME_W  = 32,
   parameter int TPD     = 25
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               eng_on,
   input  logic               active,
   input  logic [TIME_W-1:0]  ptp_time,
   input  logic [TIME_W-1:0]  start_time,
   input  logic [EPD_W-1:0]   epd,
   input  logic [IDX_W-1:0]   start_addr,
   input  logic [IDX_W-1:0]   end_idx,
   input  logic [DELTA_W-1:0] cur_delta,
   output logic               running,
   output logic [IDX_W-1:0]   idx
);
   localparam int TK_W = $clog2(TPD);

   logic [TK_W-1:0]    tk;
   logic [DELTA_W-1:0] dcnt;
   logic [TIME_W-1:0]  launch_at;
   logic [DELTA_W:0]   dnext;
   logic               tick_wrap;
   logic               last_delta;

   assign launch_at  = start_time + TIME_W'(epd) * TIME_W'(TPD);
   assign tick_wrap  = (tk == TK_W'(TPD - 1));
   assign dnext      = {1'b0, dcnt} + 1'b1;
   assign last_delta = dnext >= {1'b0, cur_delta};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         idx     <= '0;
         tk      <= '0;
         dcnt    <= '0;
      end else if (!eng_on || !active) begin
         running <= 1'b0;
      end else if (!running) begin
         if (ptp_time >= launch_at) begin
            running <= 1'b1;
            idx     <= start_addr;
            tk      <= '0;
            dcnt    <= '0;
         end
      end else if (tick_wrap) begin
         tk <= '0;
         if (last_delta) begin
            dcnt <= '0;
            idx  <= (idx == end_idx) ? start_addr : idx + 1'b1;
         end else begin
            dcnt <= dcnt + 1'b1;
         end
      end else begin
         tk <= tk + 1'b1;
      end
   end
endmodule

// File: rtl/gcl_gate_merge.sv
module gcl_gate_merge #(
   parameter int N_THR   = 8,
   parameter int N_PORTS = 4,
   parameter int N_TC    = 8,
   localparam int LO_W   = N_TC + 1 + N_PORTS
) (
   input  logic [N_THR-1:0]            running,
   input  logic [N_THR-1:0][LO_W-1:0]  ent_lo,
   output logic [N_PORTS*N_TC-1:0]     gate_open
);
   localparam int EN_BIT  = N_TC;
   localparam int DST_LSB = N_TC + 1;

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic [N_TC-1:0] closed;
      always_comb begin
         closed = '0;
         for (int t = 0; t < N_THR; t++) begin
            if (running[t] && ent_lo[t][EN_BIT] && ent_lo[t][DST_LSB+p])
               closed = closed | ent_lo[t][N_TC-1:0];
         end
      end
      assign gate_open[p*N_TC +: N_TC] = ~closed;
   end
endmodule

// File: rtl/gcl_engine.sv
module gcl_engine #(
   parameter int N_PORTS = 4,
   parameter int N_TC    = 8,
   parameter int DEPTH   = 16,
   parameter int N_THR   = 8,
   parameter int TIME_W  = 32,
   parameter int DELTA_W = 8,
   parameter int EPD_W   = 12,
   parameter int TPD     = 25,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int SEL_W  = $clog2(N_THR),
   localparam int LO_W   = N_TC + 1 + N_PORTS,
   localparam int ENT_W  = DELTA_W + LO_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tbl_we,
   input  logic [IDX_W-1:0]        tbl_addr,
   input  logic [ENT_W-1:0]        tbl_wdata,
   input  logic                    thr_we,
   input  logic [SEL_W-1:0]        thr_sel,
   input  logic [IDX_W-1:0]        thr_start,
   input  logic [IDX_W-1:0]        thr_end,
   input  logic [EPD_W-1:0]        thr_epd,
   input  logic [1:0]              clk_src,
   input  logic [SEL_W-1:0]        act_thr,
   input  logic [TIME_W-1:0]       start_time,
   input  logic [TIME_W-1:0]       ptp_time,
   input  logic                    cmd_start,
   input  logic                    cmd_stop,
   output logic                    sched_started,
   output logic                    sched_stopped,
   output logic                    cfg_err,
   output logic [N_PORTS*N_TC-1:0] gate_open
);
   import gcl_pkg::*;

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("gcl_engine: DEPTH must be a power of two of at least 2");
   end
   if (N_THR < 2 || N_THR > 8) begin : g_bad_thr
      $error("gcl_engine: N_THR must lie between 2 and 8");
   end
   if (TPD < 2) begin : g_bad_tpd
      $error("gcl_engine: TPD must be at least 2");
   end

   logic [DEPTH-1:0][ENT_W-1:0]     tbl_q;
   logic [N_THR-1:0][IDX_W-1:0]     st_q;
   logic [N_THR-1:0][IDX_W-1:0]     end_q;
   logic [N_THR-1:0][EPD_W-1:0]     epd_q;
   logic [N_THR-1:0][IDX_W-1:0]     thr_idx;
   logic [N_THR-1:0][ENT_W-1:0]     cur_ent;
   logic [N_THR-1:0][LO_W-1:0]      ent_lo;
   logic [N_THR-1:0]                thr_run;
   logic [N_THR-1:0]                thr_act;
   logic                            cfg_ok;
   logic                            eng_on;

   // Register-file table and per-thread settings
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbl_q <= '0;
         st_q  <= '0;
         end_q <= '0;
         epd_q <= '0;
      end else begin
         if (tbl_we) tbl_q[tbl_addr] <= tbl_wdata;
         if (thr_we) begin
            st_q[thr_sel]  <= thr_start;
            end_q[thr_sel] <= thr_end;
            epd_q[thr_sel] <= thr_epd;
         end
      end
   end

   gcl_cfg_check #(
      .N_THR(N_THR), .IDX_W(IDX_W), .EPD_W(EPD_W), .SEL_W(SEL_W)
   ) u_cfg (
      .end_idx(end_q), .epd(epd_q), .act_thr(act_thr), .cfg_ok(cfg_ok)
   );

   // Start / stop control; stop takes precedence
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sched_started <= 1'b0;
         sched_stopped <= 1'b1;
         cfg_err       <= 1'b0;
      end else if (cmd_stop) begin
         sched_started <= 1'b0;
         sched_stopped <= 1'b1;
      end else if (cmd_start && !sched_started && tsrc_e'(clk_src) == SRC_PTP) begin
         if (cfg_ok) begin
            sched_started <= 1'b1;
            sched_stopped <= 1'b0;
            cfg_err       <= 1'b0;
         end else begin
            cfg_err <= 1'b1;
         end
      end
   end

   assign eng_on = sched_started & ~cmd_stop;

   for (genvar t = 0; t < N_THR; t++) begin : g_thr
      assign cur_ent[t] = tbl_q[thr_idx[t]];
      assign ent_lo[t]  = cur_ent[t][LO_W-1:0];
      assign thr_act[t] = (SEL_W'(t) <= act_thr);

      gcl_thread #(
         .IDX_W(IDX_W), .DELTA_W(DELTA_W), .EPD_W(EPD_W),
         .TIME_W(TIME_W), .TPD(TPD)
      ) u_thr (
         .clk       (clk),
         .rst_n     (rst_n),
         .eng_on    (eng_on),
         .active    (thr_act[t]),
         .ptp_time  (ptp_time),
         .start_time(start_time),
         .epd       (epd_q[t]),
         .start_addr(st_q[t]),
         .end_idx   (end_q[t]),
         .cur_delta (cur_ent[t][ENT_W-1 -: DELTA_W]),
         .running   (thr_run[t]),
         .idx       (thr_idx[t])
      );
   end

   gcl_gate_merge #(
      .N_THR(N_THR), .N_PORTS(N_PORTS), .N_TC(N_TC)
   ) u_merge (
      .running(thr_run), .ent_lo(ent_lo), .gate_open(gate_open)
   );
endmodule

// File: rtl/gcl_engine_chk.sv
module gcl_engine_chk #(
   parameter int OW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic [1:0]    clk_src,
   input logic          cmd_start,
   input logic          cmd_stop,
   input logic          sched_started,
   input logic          sched_stopped,
   input logic          cfg_err,
   input logic [OW-1:0] gate_open
);
   // R1: the two status flags never agree
   a_r1_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      sched_started != sched_stopped);

   // R2: running only begins after a start pulse with PTP selected
   a_r2_start_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sched_started) |-> ($past(clk_src) == 2'd3 && $past(cmd_start)));

   // R3: a flagged error never coincides with a running schedule
   a_r3_err_not_started: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err) |-> !sched_started);

   // R8: a stop pulse halts the engine and opens every gate
   a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stop |=> (sched_stopped && (&gate_open)));

   // R8: a stopped engine keeps all gates open
   a_r8_idle_open: assert property (@(posedge clk) disable iff (!rst_n)
      sched_stopped |-> (&gate_open));
endmodule

bind gcl_engine gcl_engine_chk #(.OW(N_PORTS*N_TC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .clk_src      (clk_src),
   .cmd_start    (cmd_start),
   .cmd_stop     (cmd_stop),
   .sched_started(sched_started),
   .sched_stopped(sched_stopped),
   .cfg_err      (cfg_err),
   .gate_open    (gate_open)
);

// File: tb/tb_gcl_engine.sv
`timescale 1ns/1ps
module tb_gcl_engine;
   localparam int NP = 4, NT = 8, DEPTH = 16, NTHR = 8;
   localparam int TW = 32, DW = 8, EPDW = 12, TPD = 25;
   localparam int IW = 4, SW = 3, EW = DW + NT + 1 + NP;
   localparam int S_TIME = 100;

   // Vector: {ptp value sampled by the edge [31:16], port [15:8], expected open mask [7:0]}
   localparam logic [31:0] VEC [13] = '{
      32'h007C_00FF, 32'h007D_00F0, 32'h00AE_00F0, 32'h00AF_000E,
      32'h00AF_01FE, 32'h00C7_01FE, 32'h00C8_00F0, 32'h00C8_01FF,
      32'h00C8_02FF, 32'h00FA_000F, 32'h0112_01FF, 32'h0113_01FE,
      32'h012C_03FF
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tbl_we = 1'b0;
   logic [IW-1:0]   tbl_addr = '0;
   logic [EW-1:0]   tbl_wdata = '0;
   logic            thr_we = 1'b0;
   logic [SW-1:0]   thr_sel = '0;
   logic [IW-1:0]   thr_start = '0;
   logic [IW-1:0]   thr_end = '0;
   logic [EPDW-1:0] thr_epd = '0;
   logic [1:0]      clk_src = 2'd0;
   logic [SW-1:0]   act_thr = '0;
   logic [TW-1:0]   start_time = '0;
   logic [TW-1:0]   ptp_time;
   logic            cmd_start = 1'b0;
   logic            cmd_stop = 1'b0;
   logic            sched_started, sched_stopped, cfg_err;
   logic [NP*NT-1:0] gate_open;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk)
      if (!rst_n) ptp_time <= '0;
      else        ptp_time <= ptp_time + 1;

   gcl_engine dut (
      .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_wdata(tbl_wdata), .thr_we(thr_we), .thr_sel(thr_sel),
      .thr_start(thr_start), .thr_end(thr_end), .thr_epd(thr_epd),
      .clk_src(clk_src), .act_thr(act_thr), .start_time(start_time),
      .ptp_time(ptp_time), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
      .sched_started(sched_started), .sched_stopped(sched_stopped),
      .cfg_err(cfg_err), .gate_open(gate_open)
   );

   function automatic logic [EW-1:0] ent(input int dl, input int dst, input bit en, input int cls);
      return {DW'(dl), NP'(dst), en, NT'(cls)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_tbl(input int a, input logic [EW-1:0] d);
      @(negedge clk); tbl_we = 1'b1; tbl_addr = IW'(a); tbl_wdata = d;
      @(negedge clk); tbl_we = 1'b0;
   endtask

   task automatic wr_thr(input int t, input int sa, input int ea, input int ep);
      @(negedge clk); thr_we = 1'b1; thr_sel = SW'(t);
      thr_start = IW'(sa); thr_end = IW'(ea); thr_epd = EPDW'(ep);
      @(negedge clk); thr_we = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); cmd_start = 1'b1;
      @(negedge clk); cmd_start = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); cmd_stop = 1'b1;
      @(negedge clk); cmd_stop = 1'b0;
   endtask

   function automatic logic [7:0] port_gate(input int p);
      return gate_open[p*NT +: NT];
   endfunction

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 started", 32'(sched_started), 32'd0);
      chk("R1 stopped", 32'(sched_stopped), 32'd1);
      chk("R1 cfg_err", 32'(cfg_err), 32'd0);
      chk("R1 gates", 32'(&gate_open), 32'd1);

      // Table: e3 has enable 0 (R6), e4 belongs to inactive thread 2
      wr_tbl(0, ent(2, 4'b0001, 1'b1, 8'h0F));
      wr_tbl(1, ent(1, 4'b0001, 1'b1, 8'hF0));
      wr_tbl(2, ent(1, 4'b0011, 1'b1, 8'h01));
      wr_tbl(3, ent(3, 4'b0100, 1'b0, 8'hFF));
      wr_tbl(4, ent(1, 4'b1000, 1'b1, 8'hAA));
      wr_thr(0, 0, 1, 1);
      wr_thr(1, 2, 3, 3);
      wr_thr(2, 4, 4, 1);
      for (int t = 3; t < NTHR; t++) wr_thr(t, 0, 4, 0);
      act_thr    = SW'(1);
      start_time = TW'(S_TIME);

      // R2: free-running source must not start the engine
      clk_src = 2'd1;
      pulse_start();
      chk("R2 ignored start", 32'(sched_started), 32'd0);
      chk("R2 still stopped", 32'(sched_stopped), 32'd1);

      clk_src = 2'd3;
      pulse_start();
      chk("R2 started", 32'(sched_started), 32'd1);
      chk("R3 no error with zero delta on inactive threads", 32'(cfg_err), 32'd0);

      // Vector walk: R4 launch, R5 durations and wrap, R6 enable, R7 merge
      for (int v = 0; v < 13; v++) begin
         int n, p;
         n = int'(VEC[v][31:16]);
         p = int'(VEC[v][15:8]);
         while (ptp_time != TW'(n + 1)) @(negedge clk);
         chk($sformatf("R4 R5 R6 R7 vec %0d port %0d at %0d", v, p, n),
             32'(port_gate(p)), 32'(VEC[v][7:0]));
      end

      // R8 stop
      pulse_stop();
      chk("R8 started cleared", 32'(sched_started), 32'd0);
      chk("R8 stopped set", 32'(sched_stopped), 32'd1);
      chk("R8 gates open", 32'(&gate_open), 32'd1);

      // R3: non-monotonic end index
      wr_thr(2, 4, 2, 1);
      pulse_start();
      chk("R3 bad end flagged", 32'(cfg_err), 32'd1);
      chk("R3 bad end refused", 32'(sched_started), 32'd0);
      wr_thr(2, 4, 4, 1);
      // R3: zero entry-point delta on an active thread
      wr_thr(1, 2, 3, 0);
      pulse_start();
      chk("R3 zero delta flagged", 32'(cfg_err), 32'd1);
      chk("R3 zero delta refused", 32'(sched_started), 32'd0);
      wr_thr(1, 2, 3, 3);

      // R9: late start, launch times already passed
      pulse_start();
      chk("R9 started", 32'(sched_started), 32'd1);
      chk("R3 error cleared", 32'(cfg_err), 32'd0);
      chk("R9 not yet running", 32'(port_gate(0)), 32'hFF);
      @(negedge clk);
      chk("R9 port0 both threads", 32'(port_gate(0)), 32'hF0);
      chk("R9 port1 thread1", 32'(port_gate(1)), 32'hFE);

      summary();
      $finish;
   end
endmodule